// File: doc/BRIEF.md
# Serial-to-Parallel Capture Register

This block collects a serial bit stream into a chain of flip-flops and, on a separate command edge, copies the whole chain into an output register that holds the word steady for downstream logic. The chain is advanced by a shift clock. The output register is loaded by a storage clock. Because the two clocks are independent, a new word can be shifted in while the previous word stays on the parallel outputs.

The last chain stage is brought out as a serial cascade output, so several instances can be daisy-chained into a wider register by wiring one cascade output to the next serial input. An active-low clear empties the chain at once and leaves the output register alone. Its release is synchronized to the shift clock. The parallel outputs come with a per-bit drive enable instead of a tri-state, so the core stays fully synthesizable. A pad or wrapper turns each enable into high impedance. The interface is bit-serial and clock-qualified, so it has no valid/ready handshake and no back-pressure: every shift-clock edge consumes one bit.

Top module: `serial_capture_reg`

## Requirements
- R1: On every rising `clk_shift` edge while the chain is out of clear, stage 0 takes `ser_in` and each stage n (n ≥ 1) takes the old value of stage n-1.
- R2: `ser_out` always equals the last stage, W-1, whatever the level of `oe_n`. A bit therefore appears on `ser_out` after exactly W shift edges.
- R3: On every rising `clk_store` edge, the output register copies all chain stages in parallel, with stage n going to `par_out[n]`.
- R4: When both clocks rise together, the output register receives the chain contents from before that edge, so it trails the chain by one edge.
- R5: Driving `clr_n` low zeroes every chain stage at once, with no clock edge needed, and `ser_out` reads 0.
- R6: The clear never changes the output register. `par_out` keeps its value through assertion and release of `clr_n`.
- R7: A `clk_store` edge taken while `clr_n` is low loads all zeros into the output register.
- R8: After `clr_n` rises, the chain stays clear through the next SYNC_STAGES (default 2) `clk_shift` edges. The edge after those shifts normally.
- R9: `par_oe` is all ones while `oe_n` is low and all zeros while `oe_n` is high. `par_out` carries the output register contents in both cases.
- R10: With one instance's `ser_out` feeding a second instance's `ser_in` and the clocks shared, 2W shift edges load a 2W-bit word. The first bit shifted lands in the second instance's top stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_shift | input | 1 | Shift clock; the chain advances on its rising edge |
| clk_store | input | 1 | Storage clock; the output register loads on its rising edge |
| clr_n | input | 1 | Active-low clear of the chain: asynchronous assertion, synchronized release |
| oe_n | input | 1 | Active-low drive enable for the parallel outputs |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Cascade output, the last chain stage |
| par_out | output | W | Output register contents |
| par_oe | output | W | Per-bit drive enable for `par_out` (1 = drive, 0 = high impedance) |

## Verification
The bench goes after the edge where both clocks rise at once. A design that sampled the chain after it shifted would show the new word on that edge instead of the previous one. It pulses the clear around a loaded output register: a design that wired the clear into that register would lose the held word. It counts shift edges after release: a missing or miscounted synchronizer would capture a bit too early or too late and offset every later word by one position. Two chained instances check that the cascade tap comes from the top stage and not from some other stage, since a wrong tap would split the 16-bit word incorrectly.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_WIDTH_DEF = 8;
  localparam int unsigned SCR_SYNC_DEF  = 2;
endpackage

// File: rtl/scr_clr_sync.sv
// Clear with immediate assertion and release aligned to the shift clock.
module scr_clr_sync #(
  parameter int unsigned STAGES = scr_pkg::SCR_SYNC_DEF
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] pipe_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[N-2:0], 1'b1};
  end

  assign rst_n = pipe_q[N-1];
endmodule

// File: rtl/scr_shift_chain.sv
// Serial-in chain; stage 0 takes the input, the top stage is the cascade tap.
module scr_shift_chain #(
  parameter int unsigned W = scr_pkg::SCR_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] stages,
  output logic         tap
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[W-2:0], din};
  end

  assign stages = chain_q;
  assign tap    = chain_q[W-1];
endmodule

// File: rtl/scr_store_reg.sv
// Output holding register with per-bit drive enables.
module scr_store_reg #(
  parameter int unsigned W = scr_pkg::SCR_WIDTH_DEF
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  input  logic         oe_n,
  output logic [W-1:0] q,
  output logic [W-1:0] drv_en
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) hold_q <= d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q[i]      = hold_q[i];
    assign drv_en[i] = ~oe_n;
  end
endmodule

// File: rtl/serial_capture_reg.sv
module serial_capture_reg #(
  parameter int unsigned W           = scr_pkg::SCR_WIDTH_DEF,
  parameter int unsigned SYNC_STAGES = scr_pkg::SCR_SYNC_DEF
) (
  input  logic         clk_shift,
  input  logic         clk_store,
  input  logic         clr_n,
  input  logic         oe_n,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] par_out,
  output logic [W-1:0] par_oe
);
  logic         shift_rst_n;
  logic [W-1:0] stage_q;

  scr_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_shift),
    .clr_n (clr_n),
    .rst_n (shift_rst_n)
  );

  scr_shift_chain #(.W(W)) u_chain (
    .clk    (clk_shift),
    .rst_n  (shift_rst_n),
    .din    (ser_in),
    .stages (stage_q),
    .tap    (ser_out)
  );

  scr_store_reg #(.W(W)) u_store (
    .clk    (clk_store),
    .d      (stage_q),
    .oe_n   (oe_n),
    .q      (par_out),
    .drv_en (par_oe)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int unsigned W = scr_pkg::SCR_WIDTH_DEF
) (
  input logic         clk_shift,
  input logic         clk_store,
  input logic         clr_n,
  input logic         oe_n,
  input logic         ser_in,
  input logic         sync_n,
  input logic [W-1:0] stage_q,
  input logic [W-1:0] par_out,
  input logic [W-1:0] par_oe
);
  assert_shift_entry_R1: assert property (@(posedge clk_shift) disable iff (!clr_n)
    (sync_n && $past(sync_n)) |-> stage_q[0] == $past(ser_in));

  assert_shift_move_R1: assert property (@(posedge clk_shift) disable iff (!clr_n)
    (sync_n && $past(sync_n)) |-> stage_q[W-1:1] == $past(stage_q[W-2:0]));

  assert_store_copy_R3: assert property (@(posedge clk_store) disable iff (!clr_n)
    1'b1 |=> par_out == $past(stage_q));

  // R5 / R7: any storage edge during clear sees an empty chain
  assert_clear_empty_R5: assert property (@(posedge clk_store) disable iff (clr_n)
    1'b1 |-> stage_q == '0);

  assert_drive_enable_R9: assert property (@(posedge clk_store) disable iff (!clr_n)
    1'b1 |-> $countones(par_oe) == (oe_n ? 0 : W));
endmodule

bind serial_capture_reg scr_checker #(.W(W)) u_chk (
  .clk_shift (clk_shift),
  .clk_store (clk_store),
  .clr_n     (clr_n),
  .oe_n      (oe_n),
  .ser_in    (ser_in),
  .sync_n    (shift_rst_n),
  .stage_q   (stage_q),
  .par_out   (par_out),
  .par_oe    (par_oe)
);

// File: tb/tb_serial_capture_reg.sv
module tb_serial_capture_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  // {oe_n, word}
  localparam logic [8:0] VEC [6] = '{9'h000, 9'h1FF, 9'h0A5, 9'h05A, 9'h181, 9'h03C};

  logic clk_shift = 0, clk_store = 0, clr_n = 0, oe_n = 1, ser_in = 0;
  logic ser_out, ser_out_b;
  logic [W-1:0] par_out, par_oe, par_out_b, par_oe_b;
  int checks = 0, failures = 0;

  serial_capture_reg #(.W(W)) dut (
    .clk_shift(clk_shift), .clk_store(clk_store), .clr_n(clr_n), .oe_n(oe_n),
    .ser_in(ser_in), .ser_out(ser_out), .par_out(par_out), .par_oe(par_oe));

  serial_capture_reg #(.W(W)) dut_b (
    .clk_shift(clk_shift), .clk_store(clk_store), .clr_n(clr_n), .oe_n(oe_n),
    .ser_in(ser_out), .ser_out(ser_out_b), .par_out(par_out_b), .par_oe(par_oe_b));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    #(CLK_PERIOD/2) clk_shift = 1;
    #(CLK_PERIOD/2) clk_shift = 0;
  endtask

  task automatic store_pulse();
    #(CLK_PERIOD/2) clk_store = 1;
    #(CLK_PERIOD/2) clk_store = 0;
  endtask

  task automatic both_pulse(input logic b);
    ser_in = b;
    #(CLK_PERIOD/2) begin clk_shift = 1; clk_store = 1; end
    #(CLK_PERIOD/2) begin clk_shift = 0; clk_store = 0; end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] prev;
    logic [7:0] sh, st;
    #(CLK_PERIOD);
    // reset state
    chk("R5 reset ser_out", {15'd0, ser_out}, 16'd0);
    chk("R9 reset drive off", {8'd0, par_oe}, 16'd0);
    store_pulse();
    chk("R7 store during clear", {8'd0, par_out}, 16'd0);

    // R8: release, chain stays clear for 2 edges, then shifts
    clr_n = 1;
    shift_bit(1); shift_bit(1);
    store_pulse();
    chk("R8 held after release", {8'd0, par_out}, 16'd0);
    shift_bit(1);
    for (int i = 0; i < 7; i++) shift_bit(0);
    chk("R8 first live edge at top", {15'd0, ser_out}, 16'd1);
    for (int i = 0; i < 8; i++) shift_bit(0);

    // vector table: shift MSB first, then store
    prev = 8'h00;
    for (int v = 0; v < 6; v++) begin
      oe_n = VEC[v][8];
      for (int i = 7; i >= 1; i--) shift_bit(VEC[v][i]);
      chk("R1 seven edges expose old stage 0", {15'd0, ser_out}, {15'd0, prev[0]});
      shift_bit(VEC[v][0]);
      chk("R2 cascade tap", {15'd0, ser_out}, {15'd0, VEC[v][7]});
      store_pulse();
      chk("R3 parallel copy", {8'd0, par_out}, {8'd0, VEC[v][7:0]});
      chk("R9 drive enable", {8'd0, par_oe}, oe_n ? 16'h0000 : 16'h00FF);
      prev = VEC[v][7:0];
    end

    // R6: clear must not touch the output register
    oe_n = 0;
    clr_n = 0;
    #1;
    chk("R5 async clear", {15'd0, ser_out}, 16'd0);
    chk("R6 held through clear", {8'd0, par_out}, 16'h003C);
    #(CLK_PERIOD);
    clr_n = 1;
    shift_bit(0); shift_bit(0);
    chk("R6 held after release", {8'd0, par_out}, 16'h003C);

    // R4: tied clocks, storage trails chain by one edge
    sh = 8'h00;
    for (int i = 0; i < 10; i++) begin
      logic b;
      b = (i % 3) != 1;
      st = sh;
      sh = {sh[6:0], b};
      both_pulse(b);
      chk("R4 tied clocks trail", {8'd0, par_out}, {8'd0, st});
      chk("R4 tied chain tap", {15'd0, ser_out}, {15'd0, sh[7]});
    end

    // R10: two chained instances carry a 16-bit word
    for (int i = 15; i >= 0; i--) shift_bit(16'hC3A5 >> i);
    store_pulse();
    chk("R10 upper instance", {8'd0, par_out_b}, 16'h00C3);
    chk("R10 lower instance", {8'd0, par_out}, 16'h00A5);

    // R7 again with a loaded chain
    clr_n = 0;
    #1;
    store_pulse();
    chk("R7 store while clear", {8'd0, par_out}, 16'd0);
    clr_n = 1;

    summary();
  end
endmodule